// File: doc/BRIEF.md
# Zero-Overhead-Loop Compute Sequencer

This block is the small controller that sits beside a bit-line compute array. It holds a 256-word program of 16-bit instructions, and a single pulse on `start_i` runs that program from address 0. A two-stage pipeline moves each instruction from fetch to execute. In the execute stage the instruction either updates local state or goes out to the array as a command.

Local state is an 8-entry register file built from flip-flops and a single compare flag. The execution unit has one adder, one comparator and one logic unit. Local instructions cover immediate loads, additions, bitwise operations, compares, jumps and conditional branches.

Array commands carry an operation code and three row numbers. The row numbers are read from registers named in the instruction, and each register can optionally be incremented after use. A hardware loop unit repeats a block of instructions a counted number of times with no branch cost per iteration, and loops can nest two deep. The program ends with an end instruction, which raises `done_o`.

Top module: `loop_sequencer`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `cmd_valid_o` are low, and they stay low until `start_i` is seen high.
- R2: Starting while idle sets `busy_o` and executes from address 0 in program order. The end instruction (bits 15:14 = 11) clears `busy_o` and sets `done_o`. `done_o` stays high until the next accepted start. The run lasts N+1+B cycles from the start edge to the `done_o` edge, where N counts the instructions executed including the end instruction and B counts the taken branches.
- R3: Local class (bits 15:14 = 00) has op in bits 13:11, rd in bits 10:8, an 8-bit immediate in bits 7:0 and rs in bits 2:0. The ops are: 0 rd=imm, 1 rd=rd+imm, 2 rd=rd+rs, 3 rd=rd&rs, 4 rd=rd|rs, 5 rd=rd^rs. All arithmetic is modulo 256.
- R4: Local op 6 sets the flag to (rd < imm, unsigned) and op 7 sets it to (rd == imm). Neither changes a register. Flow class (bits 15:14 = 01) has sub-op in bits 13:12 and target in bits 7:0. Sub-op 0 always jumps, 1 jumps if the flag is set, and 2 jumps if the flag is clear. Each taken jump costs one bubble cycle.
- R5: Array class (bits 15:14 = 10) has op in bits 13:11 and row registers A in bits 10:8, B in bits 7:5 and D in bits 4:2. When it executes, `cmd_valid_o` is high for one cycle, with `cmd_op_o` set to the op and the three row outputs set to the register values.
- R6: Array bit 1 increments registers A and B after use, and bit 0 increments register D. A register named more than once increments only once.
- R7: Flow sub-op 3 is a loop instruction. It has a count register in bits 10:8 and an end address in bits 7:0. The loop body runs from the next address up to the end address, inclusive. The body executes count times, or once when the count is 0 or 1. Looping back adds no cycles.
- R8: Loops nest two deep. A loop instruction issued while two loops are active is ignored, so its body runs once.
- R9: A start pulse while `busy_o` is high has no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start the program at address 0 |
| busy_o | output | 1 | Program running |
| done_o | output | 1 | End instruction reached |
| imem_we_i | input | 1 | Instruction memory write enable |
| imem_addr_i | input | ADDR_W | Instruction memory write address |
| imem_wdata_i | input | 16 | Instruction word to write |
| cmd_valid_o | output | 1 | Array command issued this cycle |
| cmd_op_o | output | 3 | Array operation code |
| cmd_row_a_o | output | ROW_W | First source row |
| cmd_row_b_o | output | ROW_W | Second source row |
| cmd_row_d_o | output | ROW_W | Destination row |

## Verification
Directed programs target one feature each. One covers every arithmetic and logic op with wrap-around. One mixes taken and untaken branches on both flag senses, and the run length is checked to show one bubble per taken branch. One covers loop counts of 0, 1 and 3 on a single-instruction body, which is the tightest case for the loop-back decision. Further programs cover three-deep nesting, where the third level must collapse to a single pass, post-increment with aliased registers, and a start pulse in mid-run. Seeded random programs then combine local ops, array commands, nested loops and forward branches. Their command stream and cycle count are compared against an instruction-level model, which separates a correct loop and flush interplay from an off-by-one cycle or count.

// File: rtl/lseq_pkg.sv
package lseq_pkg;
  localparam int INSTR_W = 16;
  localparam int NREG    = 8;
  localparam int REG_AW  = 3;

  typedef enum logic [1:0] {CLS_ALU = 2'b00, CLS_FLOW = 2'b01, CLS_ARR = 2'b10, CLS_END = 2'b11} cls_e;
  typedef enum logic [2:0] {
    ALU_LI, ALU_ADDI, ALU_ADD, ALU_AND, ALU_OR, ALU_XOR, ALU_CMPLT, ALU_CMPEQ
  } alu_op_e;
  typedef enum logic [1:0] {FL_JMP, FL_BT, FL_BF, FL_LOOP} flow_e;
endpackage

// File: rtl/lseq_alu.sv
module lseq_alu
  import lseq_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   res_o,
  output logic           wr_o,
  output logic           flag_we_o,
  output logic           flag_o
);
  logic [W-1:0] sum;
  logic         lt, eq;

  assign sum = a_i + b_i;
  assign lt  = a_i < b_i;
  assign eq  = a_i == b_i;

  always_comb begin
    res_o     = sum;
    wr_o      = 1'b1;
    flag_we_o = 1'b0;
    flag_o    = 1'b0;
    unique case (op_i)
      ALU_LI:    res_o = b_i;
      ALU_ADDI,
      ALU_ADD:   res_o = sum;
      ALU_AND:   res_o = a_i & b_i;
      ALU_OR:    res_o = a_i | b_i;
      ALU_XOR:   res_o = a_i ^ b_i;
      ALU_CMPLT: begin wr_o = 1'b0; flag_we_o = 1'b1; flag_o = lt; end
      ALU_CMPEQ: begin wr_o = 1'b0; flag_we_o = 1'b1; flag_o = eq; end
      default:   res_o = sum;
    endcase
  end
endmodule

// File: rtl/lseq_regfile.sv
module lseq_regfile #(
  parameter int W  = 8,
  parameter int N  = 8,
  parameter int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  input  logic [AW-1:0] raddr_c_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o,
  output logic [W-1:0]  rdata_c_o,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [N-1:0]  inc_i
);
  logic [W-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           regs[g] <= '0;
      else if (we_i && waddr_i == AW'(g))    regs[g] <= wdata_i;
      else if (inc_i[g])                     regs[g] <= regs[g] + 1'b1;
    end
  end

  assign rdata_a_o = regs[raddr_a_i];
  assign rdata_b_o = regs[raddr_b_i];
  assign rdata_c_o = regs[raddr_c_i];
endmodule

// File: rtl/lseq_loop_stack.sv
module lseq_loop_stack #(
  parameter int AW    = 8,
  parameter int CW    = 8,
  parameter int DEPTH = 2,
  parameter int SPW   = $clog2(DEPTH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic           push_i,
  input  logic [AW-1:0]  push_start_i,
  input  logic [AW-1:0]  push_end_i,
  input  logic [CW-1:0]  push_cnt_i,
  input  logic           fetch_en_i,
  input  logic [AW-1:0]  fetch_pc_i,
  output logic           redirect_o,
  output logic [AW-1:0]  redirect_pc_o,
  output logic [SPW-1:0] sp_o
);
  logic [AW-1:0]  st_start [DEPTH];
  logic [AW-1:0]  st_end   [DEPTH];
  logic [CW-1:0]  st_cnt   [DEPTH];
  logic [SPW-1:0] sp_q, top_idx;
  logic           push_ok, top_vld, hit, back, pop;
  logic [AW-1:0]  t_start, t_end;
  logic [CW-1:0]  t_cnt;

  assign push_ok = push_i && (sp_q < SPW'(DEPTH));

  // a loop pushed this cycle is already visible to the fetch of its first body word
  always_comb begin
    if (push_ok) begin
      top_vld = 1'b1;
      top_idx = sp_q;
      t_start = push_start_i;
      t_end   = push_end_i;
      t_cnt   = push_cnt_i;
    end else begin
      top_vld = sp_q != '0;
      top_idx = (sp_q == '0) ? '0 : sp_q - 1'b1;
      t_start = st_start[top_idx];
      t_end   = st_end[top_idx];
      t_cnt   = st_cnt[top_idx];
    end
  end

  assign hit           = fetch_en_i && top_vld && (fetch_pc_i == t_end);
  assign back          = hit && (t_cnt > CW'(1));
  assign pop           = hit && !back;
  assign redirect_o    = back;
  assign redirect_pc_o = t_start;
  assign sp_o          = sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        st_start[i] <= '0;
        st_end[i]   <= '0;
        st_cnt[i]   <= '0;
      end
    end else if (clear_i) begin
      sp_q <= '0;
    end else begin
      if (push_ok) begin
        st_start[top_idx] <= push_start_i;
        st_end[top_idx]   <= push_end_i;
        st_cnt[top_idx]   <= back ? push_cnt_i - 1'b1 : push_cnt_i;
      end else if (back) begin
        st_cnt[top_idx] <= t_cnt - 1'b1;
      end
      sp_q <= sp_q + SPW'(push_ok) - SPW'(pop);
    end
  end
endmodule

// File: rtl/loop_sequencer.sv
module loop_sequencer
  import lseq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int ROW_W      = 8,
  parameter int LOOP_DEPTH = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  output logic               busy_o,
  output logic               done_o,
  input  logic               imem_we_i,
  input  logic [ADDR_W-1:0]  imem_addr_i,
  input  logic [INSTR_W-1:0] imem_wdata_i,
  output logic               cmd_valid_o,
  output logic [2:0]         cmd_op_o,
  output logic [ROW_W-1:0]   cmd_row_a_o,
  output logic [ROW_W-1:0]   cmd_row_b_o,
  output logic [ROW_W-1:0]   cmd_row_d_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SPW   = $clog2(LOOP_DEPTH + 1);

  logic [INSTR_W-1:0] imem [DEPTH];
  logic               busy_q, done_q, ir_vld_q, flag_q;
  logic [ADDR_W-1:0]  pc_q, ir_pc_q;
  logic [INSTR_W-1:0] ir_q;

  always_ff @(posedge clk_i) begin
    if (imem_we_i) imem[imem_addr_i] <= imem_wdata_i;
  end

  // decode
  cls_e    cls;
  alu_op_e alu_op;
  flow_e   fop;
  logic    ex_alu, ex_flow, ex_arr, ex_end;

  assign cls     = cls_e'(ir_q[15:14]);
  assign alu_op  = alu_op_e'(ir_q[13:11]);
  assign fop     = flow_e'(ir_q[13:12]);
  assign ex_alu  = ir_vld_q && cls == CLS_ALU;
  assign ex_flow = ir_vld_q && cls == CLS_FLOW;
  assign ex_arr  = ir_vld_q && cls == CLS_ARR;
  assign ex_end  = ir_vld_q && cls == CLS_END;

  // register file
  logic [ROW_W-1:0] rd_a, rd_b, rd_c, alu_b, alu_res;
  logic [NREG-1:0]  inc;
  logic             alu_wr, alu_fwe, alu_flag;

  always_comb begin
    inc = '0;
    if (ex_arr) begin
      if (ir_q[1]) begin
        inc[ir_q[10:8]] = 1'b1;
        inc[ir_q[7:5]]  = 1'b1;
      end
      if (ir_q[0]) inc[ir_q[4:2]] = 1'b1;
    end
  end

  lseq_regfile #(.W(ROW_W), .N(NREG), .AW(REG_AW)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raddr_a_i (ir_q[10:8]),
    .raddr_b_i (ex_arr ? ir_q[7:5] : ir_q[2:0]),
    .raddr_c_i (ir_q[4:2]),
    .rdata_a_o (rd_a),
    .rdata_b_o (rd_b),
    .rdata_c_o (rd_c),
    .we_i      (ex_alu && alu_wr),
    .waddr_i   (ir_q[10:8]),
    .wdata_i   (alu_res),
    .inc_i     (inc)
  );

  assign alu_b = (alu_op inside {ALU_ADD, ALU_AND, ALU_OR, ALU_XOR}) ? rd_b : ROW_W'(ir_q[7:0]);

  lseq_alu #(.W(ROW_W)) u_alu (
    .op_i      (alu_op),
    .a_i       (rd_a),
    .b_i       (alu_b),
    .res_o     (alu_res),
    .wr_o      (alu_wr),
    .flag_we_o (alu_fwe),
    .flag_o    (alu_flag)
  );

  // flow control
  logic              taken, push, flush, redirect, start_ok;
  logic [ADDR_W-1:0] target, redir_pc;
  logic [SPW-1:0]    loop_sp;

  assign target   = ir_q[ADDR_W-1:0];
  assign taken    = ex_flow && (fop == FL_JMP || (fop == FL_BT && flag_q) || (fop == FL_BF && !flag_q));
  assign push     = ex_flow && fop == FL_LOOP && rd_a > ROW_W'(1);
  assign flush    = taken || ex_end;
  assign start_ok = !busy_q && start_i;

  lseq_loop_stack #(.AW(ADDR_W), .CW(ROW_W), .DEPTH(LOOP_DEPTH), .SPW(SPW)) u_loop (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clear_i       (start_ok),
    .push_i        (push),
    .push_start_i  (ir_pc_q + 1'b1),
    .push_end_i    (target),
    .push_cnt_i    (rd_a),
    .fetch_en_i    (busy_q && !flush),
    .fetch_pc_i    (pc_q),
    .redirect_o    (redirect),
    .redirect_pc_o (redir_pc),
    .sp_o          (loop_sp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      ir_vld_q <= 1'b0;
      flag_q   <= 1'b0;
      pc_q     <= '0;
      ir_pc_q  <= '0;
      ir_q     <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q   <= 1'b1;
        done_q   <= 1'b0;
        pc_q     <= '0;
        ir_vld_q <= 1'b0;
      end
    end else begin
      if (ex_alu && alu_fwe) flag_q <= alu_flag;
      if (ex_end) begin
        busy_q   <= 1'b0;
        done_q   <= 1'b1;
        ir_vld_q <= 1'b0;
      end else if (taken) begin
        pc_q     <= target;
        ir_vld_q <= 1'b0;
      end else begin
        ir_q     <= imem[pc_q];
        ir_pc_q  <= pc_q;
        ir_vld_q <= 1'b1;
        pc_q     <= redirect ? redir_pc : pc_q + 1'b1;
      end
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign cmd_valid_o = ex_arr;
  assign cmd_op_o    = ir_q[13:11];
  assign cmd_row_a_o = rd_a;
  assign cmd_row_b_o = rd_b;
  assign cmd_row_d_o = rd_c;
endmodule

// File: rtl/lseq_checker.sv
module lseq_checker #(
  parameter int LOOP_DEPTH = 2,
  parameter int SPW        = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           busy_o,
  input logic           done_o,
  input logic           cmd_valid_o,
  input logic [SPW-1:0] sp_i
);
  assert_busy_done_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  assert_cmd_only_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> busy_o);

  assert_done_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);

  assert_busy_needs_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_loop_depth_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_i <= SPW'(LOOP_DEPTH));
endmodule

bind loop_sequencer lseq_checker #(.LOOP_DEPTH(LOOP_DEPTH), .SPW(SPW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .cmd_valid_o (cmd_valid_o),
  .sp_i        (loop_sp)
);

// File: tb/tb_loop_sequencer.sv
`timescale 1ns/1ps
module tb_loop_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy, done;
  logic        we = 1'b0;
  logic [7:0]  waddr = '0;
  logic [15:0] wdata = '0;
  logic        cv;
  logic [2:0]  cop;
  logic [7:0]  ra, rb, rd;

  always #2.5 clk = ~clk;

  loop_sequencer dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .imem_we_i(we), .imem_addr_i(waddr), .imem_wdata_i(wdata),
    .cmd_valid_o(cv), .cmd_op_o(cop), .cmd_row_a_o(ra), .cmd_row_b_o(rb), .cmd_row_d_o(rd)
  );

  int checks = 0;
  int errors = 0;

  logic [15:0] prog [256];
  int          plen;
  logic [7:0]  m_reg [8];
  logic        m_flag = 1'b0;
  logic [26:0] exp_cmd [1024];
  logic [26:0] got_cmd [1024];
  int          got_n;
  bit          mon_on = 1'b0;
  int          last_cyc;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] e_alu(int op, int r, int imm);
    return {2'b00, op[2:0], r[2:0], imm[7:0]};
  endfunction
  function automatic logic [15:0] e_flow(int sub, int r, int imm);
    return {2'b01, sub[1:0], 1'b0, r[2:0], imm[7:0]};
  endfunction
  function automatic logic [15:0] e_arr(int op, int a, int b, int d, int ia, int id);
    return {2'b10, op[2:0], a[2:0], b[2:0], d[2:0], ia[0], id[0]};
  endfunction
  function automatic logic [15:0] e_end();
    return 16'hC000;
  endfunction

  task automatic emit(logic [15:0] w);
    prog[plen] = w;
    plen++;
  endtask

  // instruction-level model: loop check at each fetch, then execute
  task automatic m_run(output int ncmd, output int cyc);
    int pc = 0, sp = 0, nexec = 0, bub = 0, nxt;
    int ls[2], le[2], lc[2];
    bit fin = 0;
    logic [15:0] ins;
    logic [7:0]  b, c;
    int op, r;
    ncmd = 0;
    while (!fin && nexec < 20000) begin
      ins = prog[pc];
      nexec++;
      nxt = (pc + 1) % 256;
      if (sp > 0 && pc == le[sp-1]) begin
        if (lc[sp-1] > 1) begin nxt = ls[sp-1]; lc[sp-1]--; end
        else sp--;
      end
      op = int'(ins[13:11]);
      r  = int'(ins[10:8]);
      case (ins[15:14])
        2'b00: begin
          b = (op >= 2 && op <= 5) ? m_reg[ins[2:0]] : ins[7:0];
          case (op)
            0: m_reg[r] = b;
            1, 2: m_reg[r] = m_reg[r] + b;
            3: m_reg[r] = m_reg[r] & b;
            4: m_reg[r] = m_reg[r] | b;
            5: m_reg[r] = m_reg[r] ^ b;
            6: m_flag = m_reg[r] < ins[7:0];
            default: m_flag = m_reg[r] == ins[7:0];
          endcase
        end
        2'b01: begin
          if (ins[13:12] == 2'd0 || (ins[13:12] == 2'd1 && m_flag) || (ins[13:12] == 2'd2 && !m_flag)) begin
            nxt = int'(ins[7:0]);
            bub++;
          end else if (ins[13:12] == 2'd3) begin
            c = m_reg[r];
            if (c >= 2 && sp < 2) begin
              ls[sp] = (pc + 1) % 256; le[sp] = int'(ins[7:0]); lc[sp] = int'(c); sp++;
            end
          end
        end
        2'b10: begin
          if (ncmd < 1024) exp_cmd[ncmd] = {ins[13:11], m_reg[r], m_reg[ins[7:5]], m_reg[ins[4:2]]};
          ncmd++;
          if (ins[1]) begin
            m_reg[r] = m_reg[r] + 1;
            if (int'(ins[7:5]) != r) m_reg[ins[7:5]] = m_reg[ins[7:5]] + 1;
          end
          if (ins[0] && !(ins[1] && (int'(ins[4:2]) == r || ins[4:2] == ins[7:5])))
            m_reg[ins[4:2]] = m_reg[ins[4:2]] + 1;
        end
        default: fin = 1;
      endcase
      pc = nxt;
    end
    cyc = nexec + 1 + bub;
  endtask

  always @(negedge clk) begin
    if (mon_on && cv) begin
      if (got_n < 1024) got_cmd[got_n] = {cop, ra, rb, rd};
      got_n++;
    end
  end

  task automatic run_prog(string req, bit mid);
    int en, ecyc, cyc;
    for (int i = 0; i < plen; i++) begin
      @(negedge clk);
      we = 1'b1; waddr = 8'(i); wdata = prog[i];
    end
    @(negedge clk);
    we = 1'b0;
    m_run(en, ecyc);
    got_n  = 0;
    mon_on = 1'b1;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc   = 0;
    while (!done && cyc < 10000) begin
      @(negedge clk);
      cyc++;
      start = mid && (cyc == 2);
    end
    start  = 1'b0;
    mon_on = 1'b0;
    last_cyc = cyc;
    chk(req, "command count", got_n, en);
    for (int i = 0; i < en && i < got_n && i < 1024; i++)
      chk("R5", $sformatf("%s command %0d {op,a,b,d}", req, i), got_cmd[i], exp_cmd[i]);
    chk(req, "cycles start to done (R2)", cyc, ecyc);
    chk("R2", "done after end", done, 1);
    chk("R2", "busy after end", busy, 0);
  endtask

  function automatic logic [15:0] rnd_op();
    if ($urandom % 2 == 0)
      return e_alu(int'($urandom % 8), int'($urandom % 8), int'($urandom % 256));
    return e_arr(int'($urandom % 8), int'($urandom % 8), int'($urandom % 8), int'($urandom % 8),
                 int'($urandom % 2), int'($urandom % 2));
  endfunction

  task automatic gen_random();
    int li, li2, rc, k;
    plen = 0;
    repeat (2) emit(e_alu(0, int'($urandom % 8), int'($urandom % 256)));
    repeat (1 + $urandom % 4) begin
      case ($urandom % 3)
        0: repeat (1 + $urandom % 3) emit(rnd_op());
        1: begin
          rc = int'($urandom % 8);
          emit(e_alu(0, rc, int'($urandom % 5)));
          li = plen; emit(16'h0);
          repeat (1 + $urandom % 2) emit(rnd_op());
          if ($urandom % 2 == 1) begin
            rc = int'($urandom % 8);
            emit(e_alu(0, rc, int'($urandom % 4)));
            li2 = plen; emit(16'h0);
            repeat (1 + $urandom % 2) emit(rnd_op());
            prog[li2] = e_flow(3, rc, plen - 1);
          end
          emit(rnd_op());
          prog[li] = e_flow(3, int'(prog[li-1][10:8]), plen - 1);
        end
        default: begin
          emit(e_alu(6 + int'($urandom % 2), int'($urandom % 8), int'($urandom % 256)));
          k = 1 + int'($urandom % 3);
          emit(e_flow(int'($urandom % 3), 0, plen + 1 + k));
          repeat (k) emit(rnd_op());
        end
      endcase
    end
    emit(e_end());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r8_cyc;
    void'($urandom(32'h5EC0_0017));
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "busy idle", busy, 0);
    chk("R1", "done idle", done, 0);
    chk("R1", "cmd_valid idle", cv, 0);

    // R3 arithmetic and logic ops
    plen = 0;
    emit(e_alu(0, 1, 5)); emit(e_alu(0, 2, 200)); emit(e_alu(1, 1, 3)); emit(e_alu(2, 2, 1));
    emit(e_arr(0, 1, 2, 2, 0, 0));
    emit(e_alu(0, 4, 8'h3C)); emit(e_alu(0, 5, 8'hF0)); emit(e_alu(3, 5, 4));
    emit(e_alu(0, 6, 8'hF0)); emit(e_alu(4, 6, 4)); emit(e_alu(0, 7, 8'hF0)); emit(e_alu(5, 7, 4));
    emit(e_arr(1, 5, 6, 7, 0, 0));
    emit(e_alu(1, 2, 100)); emit(e_arr(2, 2, 2, 2, 0, 0)); emit(e_end());
    run_prog("R3", 0);
    chk("R3", "add result", got_cmd[0], {3'd0, 8'd8, 8'd208, 8'd208});
    chk("R3", "and/or/xor", got_cmd[1], {3'd1, 8'h30, 8'hFC, 8'hCC});
    chk("R3", "add wrap", got_cmd[2], {3'd2, 8'h34, 8'h34, 8'h34});

    // R4 compares, branches, bubbles
    plen = 0;
    emit(e_alu(0, 1, 7)); emit(e_alu(6, 1, 8)); emit(e_flow(1, 0, 4)); emit(e_arr(1, 0, 0, 0, 0, 0));
    emit(e_arr(3, 0, 0, 0, 0, 0)); emit(e_alu(7, 1, 8)); emit(e_flow(1, 0, 8)); emit(e_arr(4, 0, 0, 0, 0, 0));
    emit(e_flow(2, 0, 10)); emit(e_arr(1, 0, 0, 0, 0, 0)); emit(e_arr(5, 0, 0, 0, 0, 0));
    emit(e_flow(0, 0, 13)); emit(e_arr(1, 0, 0, 0, 0, 0)); emit(e_arr(6, 0, 0, 0, 0, 0)); emit(e_end());
    run_prog("R4", 0);
    chk("R4", "commands after branches", got_n, 4);
    chk("R4", "cycles with three bubbles", last_cyc, 16);
    chk("R4", "first landing op", got_cmd[0][26:24], 3);

    // R7 loop counts 0, 1, 3
    plen = 0;
    emit(e_alu(0, 1, 0)); emit(e_flow(3, 1, 2)); emit(e_arr(1, 0, 0, 0, 0, 0));
    emit(e_alu(0, 1, 1)); emit(e_flow(3, 1, 5)); emit(e_arr(2, 0, 0, 0, 0, 0));
    emit(e_alu(0, 1, 3)); emit(e_flow(3, 1, 8)); emit(e_arr(3, 0, 0, 0, 0, 0)); emit(e_end());
    run_prog("R7", 0);
    chk("R7", "body executions", got_n, 5);
    chk("R7", "zero-overhead cycles", last_cyc, 13);

    // R8 nesting: third level ignored
    plen = 0;
    emit(e_alu(0, 1, 2)); emit(e_flow(3, 1, 8)); emit(e_alu(0, 2, 2)); emit(e_flow(3, 2, 7));
    emit(e_alu(0, 3, 3)); emit(e_flow(3, 3, 6)); emit(e_arr(1, 0, 0, 0, 0, 0));
    emit(e_arr(2, 0, 0, 0, 0, 0)); emit(e_arr(3, 0, 0, 0, 0, 0)); emit(e_end());
    run_prog("R8", 0);
    chk("R8", "nested command count", got_n, 10);
    r8_cyc = last_cyc;

    // R9 start while busy ignored
    run_prog("R9", 1);
    chk("R9", "count with mid start", got_n, 10);
    chk("R9", "cycles with mid start", last_cyc, r8_cyc);

    // R6 post-increment with aliasing
    plen = 0;
    emit(e_alu(0, 1, 10)); emit(e_alu(0, 2, 20)); emit(e_alu(0, 3, 30));
    emit(e_arr(1, 1, 2, 3, 1, 1)); emit(e_arr(1, 1, 2, 3, 0, 1)); emit(e_arr(1, 1, 1, 1, 1, 1));
    emit(e_arr(1, 1, 2, 3, 0, 0)); emit(e_end());
    run_prog("R6", 0);
    chk("R6", "after ab and d inc", got_cmd[1], {3'd1, 8'd11, 8'd21, 8'd31});
    chk("R6", "aliased inc once", got_cmd[3], {3'd1, 8'd12, 8'd21, 8'd32});

    // random programs
    for (int n = 0; n < 40; n++) begin
      gen_random();
      run_prog("R7", 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule